// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This unit is the data-processing stage of a 32-bit integer datapath. It is purely combinational: each evaluation takes an opcode, a first operand, a second operand that has already passed through the shifter, the current condition flags, the carry bit produced by the shifter and a set-flags control. From these it yields the 32-bit result, a write strobe for the destination register and the next values of the four condition flags.

Sixteen operations are supported. Six are arithmetic: forward, carry-chained and reverse subtraction, plus addition. Four are bitwise. Two are moves. The remaining four compare or test the operands and only change flags. Carry-chained forms make multi-word arithmetic possible by feeding the incoming carry flag into the adder. The flags travel as one 4-bit vector ordered {N, Z, C, V} from bit 3 down to bit 0, on both input and output.

Top module: `dp_alu`

## Requirements
- R1: The opcode encoding is 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 RSB, 5 RSC, 6 AND, 7 ORR, 8 EOR, 9 BIC, 10 MOV, 11 MVN, 12 CMP, 13 CMN, 14 TST, 15 TEQ. ADD gives A+B and ADC gives A+B+C, where C is flags_i[1]. When flags are set, C takes the unsigned carry-out of the sum. A flag-setting ADD of the low words followed by an ADC of the high words gives a correct 64-bit sum.
- R2: SUB gives A-B and SBC gives A-B+C-1. RSB gives B-A and RSC gives B-A+C-1. When flags are set, C is 1 exactly when no borrow occurs.
- R3: For all eight arithmetic opcodes (0-5, 12, 13), flags_o[0] (V) reports signed two's-complement overflow of the operation when flags update.
- R4: AND gives A&B, ORR gives A|B, EOR gives A^B and BIC gives A&~B. For example, 0x11111111 BIC 0x01100101 is 0x10011010.
- R5: MOV outputs B unchanged and MVN outputs ~B.
- R6: CMP takes flags from A-B, CMN from A+B, TST from A&B and TEQ from A^B. All four hold result_we_o low, and opcodes 0-11 hold it high.
- R7: Opcodes 12-15 update the flags whether set_flags_i is high or low.
- R8: On any flag update, N equals bit 31 of the computed value and Z is 1 exactly when that value is zero.
- R9: On a flag update by opcodes 6-11, 14 or 15, C takes shift_carry_i and V keeps flags_i[0]. For example, a flag-setting MOV of zero gives Z=1 and N=0.
- R10: With set_flags_i low, flags_o equals flags_i for opcodes 0-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encoding in R1) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry bit produced by the shifter |
| set_flags_i | input | 1 | Request a flag update for opcodes 0-11 |
| result_o | output | 32 | Computed value |
| result_we_o | output | 1 | Destination write strobe |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
Result writing and flag updating happen in the same evaluation for any writing opcode issued with set_flags_i high. The bench provokes this with directed and random vectors that assert set_flags_i alongside opcodes 0-11. Each such vector must show the written value and N/Z agreeing with that same value, while C and V come from the adder or from the shifter/old flag according to the opcode class. The opposite pairing is also covered: compare forms with set_flags_i low must still move the flags but keep result_we_o low.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_RSB = 4'd4,  OP_RSC = 4'd5,  OP_AND = 4'd6,  OP_ORR = 4'd7,
    OP_EOR = 4'd8,  OP_BIC = 4'd9,  OP_MOV = 4'd10, OP_MVN = 4'd11,
    OP_CMP = 4'd12, OP_CMN = 4'd13, OP_TST = 4'd14, OP_TEQ = 4'd15
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned FLAG_W = 4;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_test(input alu_op_e op);
    return (op inside {OP_CMP, OP_CMN, OP_TST, OP_TEQ});
  endfunction
endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add3(input logic [DATA_W-1:0] x,
                                           input logic [DATA_W-1:0] y,
                                           input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  logic [DATA_W-1:0] x, y;
  logic              ci;
  logic [DATA_W:0]   full;

  always_comb begin
    x  = a_i;
    y  = b_i;
    ci = 1'b0;
    case (op_i)
      OP_ADC:         ci = cin_i;
      OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1; end
      OP_SBC:         begin y = ~b_i; ci = cin_i; end
      OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1; end
      OP_RSC:         begin x = b_i; y = ~a_i; ci = cin_i; end
      default:        ;
    endcase
  end

  assign full   = add3(x, y, ci);
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
  assign ovf_o  = (x[MSB] == y[MSB]) && (sum_o[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] value_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TST: value_o = a_i & b_i;
      OP_ORR:         value_o = a_i | b_i;
      OP_EOR, OP_TEQ: value_o = a_i ^ b_i;
      OP_BIC:         value_o = a_i & ~b_i;
      OP_MOV:         value_o = b_i;
      OP_MVN:         value_o = ~b_i;
      default:        value_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic              update_i,
  input  logic              arith_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  input  logic              shift_carry_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    if (update_i) begin
      flags_o[FLAG_N] = value_i[DATA_W-1];
      flags_o[FLAG_Z] = (value_i == '0);
      flags_o[FLAG_C] = arith_i ? cout_i : shift_carry_i;
      flags_o[FLAG_V] = arith_i ? ovf_i  : flags_i[FLAG_V];
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        flags_i,
  input  logic              shift_carry_i,
  input  logic              set_flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_we_o,
  output logic [3:0]        flags_o
);
  alu_op_e           op;
  logic              arith_sel;
  logic              test_sel;
  logic              flag_update;
  logic [DATA_W-1:0] adder_sum;
  logic              adder_cout;
  logic              adder_ovf;
  logic [DATA_W-1:0] logic_value;
  logic [DATA_W-1:0] value;

  assign op          = alu_op_e'(op_i);
  assign arith_sel   = op_is_arith(op);
  assign test_sel    = op_is_test(op);
  assign flag_update = set_flags_i | test_sel;

  dp_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .op_i   (op),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (flags_i[FLAG_C]),
    .sum_o  (adder_sum),
    .cout_o (adder_cout),
    .ovf_o  (adder_ovf)
  );

  dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i    (op),
    .a_i     (a_i),
    .b_i     (b_i),
    .value_o (logic_value)
  );

  assign value = arith_sel ? adder_sum : logic_value;

  dp_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .value_i       (value),
    .update_i      (flag_update),
    .arith_i       (arith_sel),
    .cout_i        (adder_cout),
    .ovf_i         (adder_ovf),
    .shift_carry_i (shift_carry_i),
    .flags_i       (flags_i),
    .flags_o       (flags_o)
  );

  assign result_o    = value;
  assign result_we_o = ~test_sel;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic [3:0]        op_i,
  input logic [3:0]        flags_i,
  input logic              shift_carry_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_we_o,
  input logic [3:0]        flags_o,
  input logic              arith_sel,
  input logic              flag_update,
  input logic              adder_cout,
  input logic              adder_ovf
);
  always_comb begin
    if (!$isunknown({op_i, flags_i, shift_carry_i, set_flags_i, result_o,
                     result_we_o, flags_o, arith_sel, flag_update,
                     adder_cout, adder_ovf})) begin
      a_r10_flags_hold: assert (!(!set_flags_i && result_we_o) || flags_o == flags_i)
        else $error("R10 flags changed without set-flags");
      a_r7_test_updates: assert (result_we_o || flag_update)
        else $error("R7 compare form did not update flags");
      a_r8_nz_track: assert (!(flag_update && result_we_o) ||
                             (flags_o[2] == (result_o == '0) && flags_o[3] == result_o[DATA_W-1]))
        else $error("R8 N/Z disagree with written value");
      a_r9_logic_cv: assert (!(flag_update && !arith_sel) ||
                             (flags_o[1] == shift_carry_i && flags_o[0] == flags_i[0]))
        else $error("R9 logical C/V wrong");
      a_r2_adder_carry: assert (!(flag_update && arith_sel) || flags_o[1] == adder_cout)
        else $error("R2 carry not from adder");
      a_r3_overflow: assert (!(flag_update && arith_sel) || flags_o[0] == adder_ovf)
        else $error("R3 overflow not from adder");
    end
  end
endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .op_i          (op_i),
  .flags_i       (flags_i),
  .shift_carry_i (shift_carry_i),
  .set_flags_i   (set_flags_i),
  .result_o      (result_o),
  .result_we_o   (result_we_o),
  .flags_o       (flags_o),
  .arith_sel     (arith_sel),
  .flag_update   (flag_update),
  .adder_cout    (adder_cout),
  .adder_ovf     (adder_ovf)
);

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [3:0]  flags_i = '0;
  logic        shift_carry_i = 1'b0, set_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        result_we_o;
  logic [3:0]  flags_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dp_alu dut (.*);

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:             return "R1";
      4'd2, 4'd3, 4'd4, 4'd5: return "R2";
      4'd6, 4'd7, 4'd8, 4'd9: return "R4";
      4'd10, 4'd11:           return "R5";
      default:                return "R6";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic sc, input logic s,
                       output logic [31:0] r, output logic we, output logic [3:0] fo);
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint c  = longint'(f[1]);
    longint ur = 0, sr = 0;
    bit arith = 1, is_add = 1;
    logic carry, ovf;
    case (op)
      4'd0, 4'd13: begin ur = ua + ub;          sr = sa + sb; end
      4'd1:        begin ur = ua + ub + c;      sr = sa + sb + c; end
      4'd2, 4'd12: begin ur = ua - ub;          sr = sa - sb;         is_add = 0; end
      4'd3:        begin ur = ua - ub + c - 1;  sr = sa - sb + c - 1; is_add = 0; end
      4'd4:        begin ur = ub - ua;          sr = sb - sa;         is_add = 0; end
      4'd5:        begin ur = ub - ua + c - 1;  sr = sb - sa + c - 1; is_add = 0; end
      default:     arith = 0;
    endcase
    if (arith) begin
      r = ur[31:0];
      carry = is_add ? (ur > 64'sd4294967295) : (ur >= 0);
      ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (op)
        4'd6, 4'd14: r = a & b;
        4'd7:        r = a | b;
        4'd8, 4'd15: r = a ^ b;
        4'd9:        r = a & ~b;
        4'd10:       r = b;
        default:     r = ~b;
      endcase
      carry = sc;
      ovf = f[0];
    end
    we = (op < 4'd12);
    if (s || !we) fo = {r[31], (r == 32'd0), carry, ovf};
    else fo = f;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic sc, input logic s, input string req);
    logic [31:0] er; logic ewe; logic [3:0] ef;
    @(posedge clk);
    op_i = op; a_i = a; b_i = b; flags_i = f; shift_carry_i = sc; set_flags_i = s;
    @(negedge clk);
    model(op, a, b, f, sc, s, er, ewe, ef);
    if (ewe) check(req, "result", result_o, er);
    check(req, "write strobe", {31'b0, result_we_o}, {31'b0, ewe});
    check(req, "flags", {28'b0, flags_o}, {28'b0, ef});
  endtask

  initial begin
    logic [3:0] cflags;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-state inputs: ADD of zeros, no flag update
    check("R1", "idle result", result_o, 32'd0);
    check("R10", "idle flags", {28'b0, flags_o}, 32'd0);
    // R4 bit-clear example
    apply(4'd9, 32'h11111111, 32'h01100101, 4'b0000, 1'b0, 1'b1, "R4");
    check("R4", "bic value", result_o, 32'h10011010);
    // R1 64-bit chain: low words then high words with carry
    apply(4'd0, 32'hF0000000, 32'h10000000, 4'b0000, 1'b0, 1'b1, "R1");
    check("R1", "low sum", result_o, 32'h0);
    cflags = flags_o;
    check("R1", "low carry", {31'b0, cflags[1]}, 32'd1);
    apply(4'd1, 32'h00000001, 32'h00000000, cflags, 1'b0, 1'b1, "R1");
    check("R1", "high sum", result_o, 32'h2);
    // R9 flag-setting move of zero
    apply(4'd10, 32'h5, 32'h0, 4'b1011, 1'b1, 1'b1, "R9");
    check("R9", "mov zero flags", {28'b0, flags_o}, 32'b0111);
    // R3 signed overflow on subtract
    apply(4'd2, 32'h80000000, 32'h1, 4'b0000, 1'b0, 1'b1, "R3");
    check("R3", "sub overflow V", {31'b0, flags_o[0]}, 32'd1);
    // R2 borrow case gives C=0, reverse forms
    apply(4'd2, 32'h1, 32'h2, 4'b0010, 1'b0, 1'b1, "R2");
    check("R2", "borrow C", {31'b0, flags_o[1]}, 32'd0);
    apply(4'd5, 32'h3, 32'h10, 4'b0000, 1'b0, 1'b1, "R2");
    check("R2", "rsc value", result_o, 32'hC);
    // R7 compare with set-flags low still updates; R6 no write
    apply(4'd12, 32'h7, 32'h7, 4'b0000, 1'b0, 1'b0, "R7");
    check("R7", "cmp equal Z", {31'b0, flags_o[2]}, 32'd1);
    check("R6", "cmp no write", {31'b0, result_we_o}, 32'd0);
    // R10 writing op with set-flags low holds flags
    apply(4'd4, 32'h9, 32'h2, 4'b1010, 1'b0, 1'b0, "R10");
    check("R10", "held flags", {28'b0, flags_o}, 32'b1010);
    // R8 negative result sets N
    apply(4'd11, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b1, "R8");
    check("R8", "mvn N", {31'b0, flags_o[3]}, 32'd1);
    // random sweep over every opcode
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 60; k++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = (k % 4 == 0) ? ra : $urandom;
        if (k % 7 == 0) ra = 32'h7FFFFFFF;
        apply(op[3:0], ra, rb, 4'($urandom), 1'($urandom), 1'($urandom), req_of(op[3:0]));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule